// File: doc/BRIEF.md
# Power Management Event Status Register

This block keeps the sticky status of a small set of platform power events and pairs each one that can interrupt with an enable bit. A status bit that is set and enabled is steered to one of two level outputs. The system-control interrupt `sci` is used when the global `sci_en` input is high. The active-low management interrupt `smi_n` is used when it is low. A separate global-release event always goes to `sci`, and a bus-master activity bit is recorded but never interrupts. While the platform sleeps, enabled wake sources set a wake status bit and raise a wake request. That request stays up until the sleep controller signals that the wake has completed.

Software reaches the block through one 32-bit read/write port with two addresses. Address 0 is the event word. Its low byte holds the status bits, which are cleared by writing 1. The enables sit in the next byte. Address 1 reads back a free-running timer, which counts on a clock-enable strobe. Its overflow event sets each time a chosen high bit of the timer falls.

Top module: `pm_evt_status`

## Requirements
- R1: For the alarm (status bit 0, enable bit 8), power button (status bit 1, enable bit 9) and timer overflow (status bit 2, enable bit 10) events: with the enable at 0 neither output asserts; with the enable at 1 and `sci_en` at 0, `smi_n` is driven low; with both at 1, `sci` is driven high. Both outputs are levels that hold while the qualifying pair stays set.
- R2: Global status (bit 3) together with its enable (bit 11) drives `sci` high whatever `sci_en` is. It never pulls `smi_n` low and never sets wake status.
- R3: The timer advances by one on each cycle with `tmr_tick` high. Its value reads at address 1, zero-extended. Timer status (bit 2) sets in the same cycle that timer bit `TMR_BIT` falls from 1 to 0.
- R4: The status bits in 0..6 are set only by their hardware sources. Writing 1 to one of them at address 0 clears it, and writing 0 leaves it unchanged. If a source sets a bit in the same cycle that it is cleared, the bit stays set.
- R5: PCIe wake status (bit 5) is set every cycle that `pcie_wake_n` is low, `pcie_beacon` is high or `pcie_pme` is high. A clear written while any of them is active has no effect.
- R6: The PCIe wake disable bit (bit 13) stops PCIe activity from setting wake status or `wake_req`. It does not change PCIe wake status.
- R7: While `sleeping` is high, any of the following sets wake status (bit 6) and raises `wake_req` on the next cycle: an alarm with its enable set, a power-button press with its enable set, or PCIe activity while PCIe wake is not disabled. `wake_req` holds until `wake_done` is pulsed. Wake status holds until it is cleared by a write.
- R8: While `deep_sleep` is high, `sci` stays low and `smi_n` stays high even if an enabled event is pending, so the wake comes first. Once `deep_sleep` drops, the pending event drives its output.
- R9: Bus-master status (bit 4) is set by a `bm_req` pulse and on every cycle that `bm_busy` is high. It never drives `sci` or `smi_n` and never sets wake status.
- R10: At address 0, bits 7, 12 and 14..31 read 0 and ignore writes. The enables at bits 8..11 and 13 are read/write.
- R11: After reset all status bits, enables and the timer are 0, `sci` is low, `smi_n` is high and `wake_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | 0 = event word, 1 = timer value |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr` (combinational) |
| sci_en | input | 1 | Route enabled events to `sci` (1) or `smi_n` (0) |
| sleeping | input | 1 | Platform is in a sleep state |
| deep_sleep | input | 1 | Platform is in a deep sleep state |
| rtc_alarm | input | 1 | Alarm event pulse |
| pwr_btn | input | 1 | Power button event pulse |
| bm_req | input | 1 | Bus-master memory request pulse |
| bm_busy | input | 1 | Bus-master busy level |
| glb_release | input | 1 | Global release event pulse |
| tmr_tick | input | 1 | Timer clock-enable strobe |
| pcie_wake_n | input | 1 | PCIe wake pin, active low |
| pcie_beacon | input | 1 | PCIe beacon level |
| pcie_pme | input | 1 | PCIe power-management event level |
| wake_done | input | 1 | Wake transition finished, drops `wake_req` |
| sci | output | 1 | System-control interrupt, active high |
| smi_n | output | 1 | Management interrupt, active low |
| wake_req | output | 1 | Request to leave the sleep state |

## Verification
A status bit that is wrongly stuck shows on the next read of address 0. If it is enabled, it also shows on `sci` or `smi_n` in the cycle after the edge that captured it. A routing fault shows up as the wrong output for a given `sci_en`, and the stimulus table walks those combinations for the alarm and power-button events. An off-by-one in the timer shows as a wrong value at address 1, or as overflow status appearing one tick early or late, so the bench reads both on the tick before the falling edge and on the tick of it. A fault in the wake path shows as `wake_req` failing to rise one edge after an enabled source while sleeping, or failing to hold until `wake_done`.

// File: rtl/pmev_pkg.sv
// Package: bit positions and enable type shared by the event register block.
// Assumes the status field sits in the low byte of the event word and the
// enables in the byte above it.
package pmev_pkg;
    localparam int ST_RTC  = 0;
    localparam int ST_PWR  = 1;
    localparam int ST_TMR  = 2;
    localparam int ST_GLB  = 3;
    localparam int ST_BM   = 4;
    localparam int ST_PCIE = 5;
    localparam int ST_WAKE = 6;
    localparam int NSTAT   = 7;

    localparam int EN_RTC      = 8;
    localparam int EN_PWR      = 9;
    localparam int EN_TMR      = 10;
    localparam int EN_GLB      = 11;
    localparam int EN_PCIE_DIS = 13;

    localparam int NWAKE = 3;  // alarm, power button, PCIe

    typedef struct packed {
        logic pcie_dis;
        logic glb;
        logic tmr;
        logic pwr;
        logic rtc;
    } pmev_en_t;
endpackage

// File: rtl/pmev_timer.sv
// Module: free-running counter with a falling-edge detect on one bit.
// Assumes BIT < W. ovf is combinational so the status bit captures it on the
// same edge that moves the counter past the falling edge.
module pmev_timer #(
    parameter int W   = 24,
    parameter int BIT = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] cnt_nxt;

    // Next count value.
    assign cnt_nxt = cnt + W'(1);

    // Overflow when the watched bit goes from 1 to 0 on this tick.
    assign ovf = tick && cnt[BIT] && !cnt_nxt[BIT];

    // Counter register, advancing on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_nxt;
    end

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == W'($past(cnt) + W'(1)))); // R3
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R3
endmodule

// File: rtl/pmev_status.sv
// Module: bank of sticky status bits that are cleared by writing 1.
// Assumes set and clr are single-cycle qualified vectors. A set in the same
// cycle as a clear wins, which also gives level sources their re-set.
module pmev_status #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q_r;

        // One sticky bit: hardware set dominates software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_r <= 1'b0;
            else
                q_r <= set[i] | (q_r & ~clr[i]);
        end

        assign q[i] = q_r;

        AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]); // R4
        AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]); // R4
    end
endmodule

// File: rtl/pmev_wake.sv
// Module: wake detection and the held wake request.
// Assumes the sources are already qualified by their enable or disable bits
// through src_mask. The request holds until the sleep controller acknowledges.
module pmev_wake #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleeping,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] src_mask,
    input  logic            wake_done,
    output logic            wake_evt,
    output logic            wake_req
);
    // An enabled source seen while asleep is a wake event.
    assign wake_evt = sleeping && |(src & src_mask);

    // Held request: a new event dominates the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_req <= 1'b0;
        else if (wake_evt)
            wake_req <= 1'b1;
        else if (wake_done)
            wake_req <= 1'b0;
    end

    AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> wake_req); // R7
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_done) |=> wake_req); // R7
    AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wake_req) && wake_req) |-> $past(sleeping)); // R7
endmodule

// File: rtl/pmev_route.sv
// Module: steers enabled status to the SCI or SMI# level outputs.
// Assumes status and enables come straight from registers, so the outputs
// follow them with no added cycle. Deep sleep masks both outputs.
module pmev_route
    import pmev_pkg::*;
(
    input  logic [NSTAT-1:0] stat,
    input  pmev_en_t         en,
    input  logic             sci_en,
    input  logic             deep_sleep,
    output logic             sci,
    output logic             smi_n
);
    logic evt_pend;
    logic glb_pend;

    // Pending events that follow the SCI/SMI# steering.
    assign evt_pend = (stat[ST_RTC] & en.rtc)
                    | (stat[ST_PWR] & en.pwr)
                    | (stat[ST_TMR] & en.tmr);

    // Global event, always routed to SCI.
    assign glb_pend = stat[ST_GLB] & en.glb;

    // Output drive, held back while in deep sleep.
    always_comb begin
        sci   = !deep_sleep && ((evt_pend && sci_en) || glb_pend);
        smi_n = !(!deep_sleep && evt_pend && !sci_en);
    end
endmodule

// File: rtl/pm_evt_status.sv
// Module: power management event status register, top level.
// Address 0: status bits 0..6 (cleared by writing 1), enables 8..11 and 13.
// Address 1: timer value, zero-extended. Writes are full 32-bit words.
// Assumes TMR_W <= 32 and TMR_BIT < TMR_W.
module pm_evt_status
    import pmev_pkg::*;
#(
    parameter int TMR_W   = 24,
    parameter int TMR_BIT = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] rd_data,
    input  logic        sci_en,
    input  logic        sleeping,
    input  logic        deep_sleep,
    input  logic        rtc_alarm,
    input  logic        pwr_btn,
    input  logic        bm_req,
    input  logic        bm_busy,
    input  logic        glb_release,
    input  logic        tmr_tick,
    input  logic        pcie_wake_n,
    input  logic        pcie_beacon,
    input  logic        pcie_pme,
    input  logic        wake_done,
    output logic        sci,
    output logic        smi_n,
    output logic        wake_req
);
    localparam int PAD_W = 32 - TMR_W;

    pmev_en_t          en_q;
    logic [NSTAT-1:0]  stat_q;
    logic [NSTAT-1:0]  stat_set;
    logic [NSTAT-1:0]  stat_clr;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_ovf;
    logic              pcie_act;
    logic              wake_evt;
    logic              ev_wr;
    logic [NWAKE-1:0]  wk_src;
    logic [NWAKE-1:0]  wk_mask;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:14], reg_wdata[12], reg_wdata[7]};

    // Write to the event word this cycle.
    assign ev_wr = reg_wr && !reg_addr;

    // Any PCIe wake indication is active.
    assign pcie_act = !pcie_wake_n || pcie_beacon || pcie_pme;

    // Enable register, read/write through address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ev_wr) begin
            en_q.rtc      <= reg_wdata[EN_RTC];
            en_q.pwr      <= reg_wdata[EN_PWR];
            en_q.tmr      <= reg_wdata[EN_TMR];
            en_q.glb      <= reg_wdata[EN_GLB];
            en_q.pcie_dis <= reg_wdata[EN_PCIE_DIS];
        end
    end

    // Hardware set sources for each status bit.
    always_comb begin
        stat_set          = '0;
        stat_set[ST_RTC]  = rtc_alarm;
        stat_set[ST_PWR]  = pwr_btn;
        stat_set[ST_TMR]  = tmr_ovf;
        stat_set[ST_GLB]  = glb_release;
        stat_set[ST_BM]   = bm_req || bm_busy;
        stat_set[ST_PCIE] = pcie_act;
        stat_set[ST_WAKE] = wake_evt;
    end

    // Software clear: writing 1 to a status bit position.
    assign stat_clr = ev_wr ? reg_wdata[NSTAT-1:0] : '0;

    // Wake sources and their qualification.
    assign wk_src  = {pcie_act, pwr_btn, rtc_alarm};
    assign wk_mask = {!en_q.pcie_dis, en_q.pwr, en_q.rtc};

    pmev_timer #(
        .W   (TMR_W),
        .BIT (TMR_BIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tmr_tick),
        .cnt   (tmr_cnt),
        .ovf   (tmr_ovf)
    );

    pmev_status #(
        .N (NSTAT)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .clr   (stat_clr),
        .q     (stat_q)
    );

    pmev_wake #(
        .NSRC (NWAKE)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleeping  (sleeping),
        .src       (wk_src),
        .src_mask  (wk_mask),
        .wake_done (wake_done),
        .wake_evt  (wake_evt),
        .wake_req  (wake_req)
    );

    pmev_route u_route (
        .stat       (stat_q),
        .en         (en_q),
        .sci_en     (sci_en),
        .deep_sleep (deep_sleep),
        .sci        (sci),
        .smi_n      (smi_n)
    );

    // Read multiplexer; reserved positions return 0.
    always_comb begin
        if (reg_addr)
            rd_data = {{PAD_W{1'b0}}, tmr_cnt};
        else
            rd_data = {18'b0, en_q.pcie_dis, 1'b0, en_q.glb, en_q.tmr,
                       en_q.pwr, en_q.rtc, 1'b0, stat_q};
    end

    AST_SMI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> !sci_en); // R1
    AST_DEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> (!sci && smi_n)); // R8
    AST_PCIE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pcie_act |=> stat_q[ST_PCIE]); // R5
    AST_TMR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_cnt[TMR_BIT]) |-> stat_q[ST_TMR]); // R3
    AST_GLB_SCI: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[ST_GLB] && en_q.glb && !deep_sleep) |-> sci); // R2
endmodule

// File: tb/pm_evt_status_tb.sv
module pm_evt_status_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_addr;
    logic [31:0] reg_wdata, rd_data;
    logic        sci_en, sleeping, deep_sleep;
    logic        rtc_alarm, pwr_btn, bm_req, bm_busy, glb_release, tmr_tick;
    logic        pcie_wake_n, pcie_beacon, pcie_pme, wake_done;
    logic        sci, smi_n, wake_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pm_evt_status #(.TMR_W(8), .TMR_BIT(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .sci_en(sci_en),
        .sleeping(sleeping), .deep_sleep(deep_sleep), .rtc_alarm(rtc_alarm),
        .pwr_btn(pwr_btn), .bm_req(bm_req), .bm_busy(bm_busy),
        .glb_release(glb_release), .tmr_tick(tmr_tick),
        .pcie_wake_n(pcie_wake_n), .pcie_beacon(pcie_beacon),
        .pcie_pme(pcie_pme), .wake_done(wake_done), .sci(sci),
        .smi_n(smi_n), .wake_req(wake_req)
    );

    // Vector fields: [4] source (0 alarm, 1 power button), [3] enable,
    // [2] sci_en, [1] expected sci, [0] expected smi_n.
    localparam logic [4:0] VEC [6] = '{
        5'b0_0_0_0_1, 5'b0_1_0_0_0, 5'b0_1_1_1_1,
        5'b1_0_1_0_1, 5'b1_1_0_0_0, 5'b1_1_1_1_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        case (s)
            0: rtc_alarm = 1'b1;
            1: pwr_btn = 1'b1;
            2: glb_release = 1'b1;
            3: bm_req = 1'b1;
            default: pcie_pme = 1'b1;
        endcase
        @(negedge clk);
        rtc_alarm = 1'b0; pwr_btn = 1'b0; glb_release = 1'b0;
        bm_req = 1'b0; pcie_pme = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        sci_en = 1'b0; sleeping = 1'b0; deep_sleep = 1'b0;
        rtc_alarm = 1'b0; pwr_btn = 1'b0; bm_req = 1'b0; bm_busy = 1'b0;
        glb_release = 1'b0; tmr_tick = 1'b0; pcie_wake_n = 1'b1;
        pcie_beacon = 1'b0; pcie_pme = 1'b0; wake_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(1'b0, d); chk("R11 event word", d, 32'h0);
        rd(1'b1, d); chk("R11 timer", d, 32'h0);
        chk("R11 sci", {31'b0, sci}, 32'h0);
        chk("R11 smi_n", {31'b0, smi_n}, 32'h1);
        chk("R11 wake_req", {31'b0, wake_req}, 32'h0);

        // R1 routing table
        for (int i = 0; i < 6; i++) begin
            wr(1'b0, 32'h7F | (32'(VEC[i][3]) << (8 + 32'(VEC[i][4]))));
            sci_en = VEC[i][2];
            pulse(int'(VEC[i][4]));
            chk($sformatf("R1 vec%0d sci", i), {31'b0, sci}, {31'b0, VEC[i][1]});
            chk($sformatf("R1 vec%0d smi_n", i), {31'b0, smi_n}, {31'b0, VEC[i][0]});
            // level output still held one cycle later
            @(negedge clk);
            chk($sformatf("R1 vec%0d held", i), {30'b0, sci, smi_n}, {30'b0, VEC[i][1], VEC[i][0]});
        end
        wr(1'b0, 32'h7F);
        chk("R1 cleared quiet", {30'b0, sci, smi_n}, 32'h1);

        // R4 write-one-to-clear semantics
        pulse(0);
        wr(1'b0, 32'h0);
        rd(1'b0, d); chk("R4 write 0 keeps", d & 32'h7F, 32'h1);
        wr(1'b0, 32'h1);
        rd(1'b0, d); chk("R4 write 1 clears", d & 32'h7F, 32'h0);
        @(negedge clk);
        rtc_alarm = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h1;
        @(negedge clk);
        rtc_alarm = 1'b0; reg_wr = 1'b0;
        rd(1'b0, d); chk("R4 set beats clear", d & 32'h7F, 32'h1);
        wr(1'b0, 32'h7F);

        // R2 global event always to sci, never smi_n or wake
        sci_en = 1'b0; sleeping = 1'b1;
        wr(1'b0, 32'h0800);
        pulse(2);
        chk("R2 sci", {31'b0, sci}, 32'h1);
        chk("R2 smi_n", {31'b0, smi_n}, 32'h1);
        rd(1'b0, d); chk("R2 no wake status", d & 32'h7F, 32'h8);
        chk("R2 no wake_req", {31'b0, wake_req}, 32'h0);
        wr(1'b0, 32'h7F);
        sleeping = 1'b0;

        // R9 bus master: level and pulse, no interrupt or wake
        wr(1'b0, 32'h0F00); sci_en = 1'b1; sleeping = 1'b1;
        @(negedge clk); bm_busy = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b0, d); chk("R9 busy sets", d & 32'h7F, 32'h10);
        wr(1'b0, 32'h0F10);
        rd(1'b0, d); chk("R9 busy re-sets", d & 32'h7F, 32'h10);
        bm_busy = 1'b0;
        wr(1'b0, 32'h0F10);
        pulse(3);
        rd(1'b0, d); chk("R9 req sets", d & 32'h7F, 32'h10);
        chk("R9 no irq", {30'b0, sci, smi_n, wake_req}, 32'h2);
        sleeping = 1'b0;
        wr(1'b0, 32'h7F);

        // R5 PCIe level re-set
        @(negedge clk); pcie_pme = 1'b1;
        wr(1'b0, 32'h20);
        rd(1'b0, d); chk("R5 clear ignored while active", d & 32'h7F, 32'h20);
        pcie_pme = 1'b0; pcie_wake_n = 1'b0;
        wr(1'b0, 32'h20);
        rd(1'b0, d); chk("R5 wake pin holds", d & 32'h7F, 32'h20);
        pcie_wake_n = 1'b1;
        wr(1'b0, 32'h20);
        rd(1'b0, d); chk("R5 clear after release", d & 32'h7F, 32'h0);

        // R6 PCIe wake disable
        sleeping = 1'b1;
        wr(1'b0, 32'h2000);
        pulse(4);
        rd(1'b0, d); chk("R6 status still sets", d & 32'h7F, 32'h20);
        chk("R6 no wake_req", {31'b0, wake_req}, 32'h0);
        wr(1'b0, 32'h7F);
        pulse(4);
        rd(1'b0, d); chk("R6 enabled wake", d & 32'h7F, 32'h60);
        chk("R6 wake_req", {31'b0, wake_req}, 32'h1);

        // R7 wake request handshake
        @(negedge clk); wake_done = 1'b1;
        @(negedge clk); wake_done = 1'b0;
        chk("R7 wake_done drops", {31'b0, wake_req}, 32'h0);
        rd(1'b0, d); chk("R7 wake status sticky", d & 32'h40, 32'h40);
        wr(1'b0, 32'h7F);
        pulse(1);
        chk("R7 disabled source no wake", {31'b0, wake_req}, 32'h0);
        wr(1'b0, 32'h027F);
        pulse(1);
        chk("R7 power button wake", {31'b0, wake_req}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R7 wake_req held", {31'b0, wake_req}, 32'h1);
        @(negedge clk); wake_done = 1'b1;
        @(negedge clk); wake_done = 1'b0;
        sleeping = 1'b0;
        wr(1'b0, 32'h7F);

        // R8 deep sleep: wake first, interrupt afterwards
        sleeping = 1'b1; deep_sleep = 1'b1; sci_en = 1'b1;
        wr(1'b0, 32'h0100);
        pulse(0);
        chk("R8 wake_req", {31'b0, wake_req}, 32'h1);
        chk("R8 sci held off", {30'b0, sci, smi_n}, 32'h1);
        @(negedge clk); deep_sleep = 1'b0; sleeping = 1'b0;
        #1;
        chk("R8 sci after wake", {31'b0, sci}, 32'h1);
        sci_en = 1'b0;
        @(negedge clk); deep_sleep = 1'b1;
        #1;
        chk("R8 smi held off", {31'b0, smi_n}, 32'h1);
        deep_sleep = 1'b0;
        @(negedge clk); wake_done = 1'b1;
        @(negedge clk); wake_done = 1'b0;
        wr(1'b0, 32'h7F);

        // R10 reserved bits
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); chk("R10 reserved read 0", d, 32'h2F00);
        wr(1'b0, 32'h0000_0000);
        rd(1'b0, d); chk("R10 enables cleared", d, 32'h0);

        // R3 timer and overflow (bench build: 8-bit timer, bit 6)
        sci_en = 1'b1;
        wr(1'b0, 32'h047F);
        @(negedge clk); tmr_tick = 1'b1;
        repeat (127) @(negedge clk);
        tmr_tick = 1'b0;
        rd(1'b1, d); chk("R3 timer count", d, 32'd127);
        rd(1'b0, d); chk("R3 no early overflow", d & 32'h4, 32'h0);
        chk("R1 timer sci idle", {31'b0, sci}, 32'h0);
        @(negedge clk); tmr_tick = 1'b1;
        @(negedge clk); tmr_tick = 1'b0;
        rd(1'b1, d); chk("R3 timer 128", d, 32'd128);
        rd(1'b0, d); chk("R3 overflow set", d & 32'h4, 32'h4);
        chk("R1 timer sci", {31'b0, sci}, 32'h1);
        repeat (5) @(negedge clk);
        rd(1'b1, d); chk("R3 timer holds without tick", d, 32'd128);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule